// File: doc/BRIEF.md
# SDRAM Bank Timing Tracker

This block sits in front of the command port of an SDRAM controller that drives a four-bank device. In every cycle the scheduler presents one candidate command with a bank number, a row and an auto-precharge flag. The block answers with a combinational grant in the same cycle. When the grant is high, the command is taken at the next rising edge and the block updates what it knows about the banks. Each bank is either closed or open on a row. The block also holds the countdowns that keep the next activate, access or precharge from arriving too early.

Each bank runs a small state machine with three states:

- **IDLE** means the bank is closed. It may still be waiting out its precharge or row-cycle spacing.
- **OPEN** means a row is active.
- **APWAIT** means an access with auto-precharge has been accepted. The bank is locked until its internal precharge begins.

The transitions are:

- *activate* moves IDLE to OPEN.
- *precharge* moves OPEN to IDLE. Both the explicit precharge and precharge-all take this path.
- *auto-close arm* moves OPEN to APWAIT, on a read or write with the flag set.
- *internal precharge* moves APWAIT to IDLE, once the burst window and the minimum active time have both run out.

A single counter shared by all banks spaces activates to different banks. All timing limits are parameters given in clock cycles. The defaults suit a 7.5 ns clock.

Top module: `bank_gate`

## Requirements
- R1: After reset every bank is closed, `bank_open_o` is 0 and `open_row_o` is all zeros.
- R2: An activate is granted only to a closed bank. From the next cycle that bank reads open, and its row appears on `open_row_o[b*ROW_W +: ROW_W]` for bank b. The row stays there until the next activate of that bank.
- R3: A read or write is granted only to an open bank and no earlier than T_RCD cycles after its activate (default 3).
- R4: Two activates to different banks are at least T_RRD cycles apart (default 2).
- R5: An activate to a bank comes no earlier than T_RC cycles after that bank's previous activate or after a refresh (default 9).
- R6: A precharge to an open bank is granted no earlier than T_RAS cycles after its activate (default 6) and closes the bank. The next activate of that bank comes no earlier than T_RP cycles later (default 3).
- R7: A precharge to a closed bank is granted and has no effect. It does not delay a following activate.
- R8: A read with auto-precharge at cycle t locks the bank, and reads, writes and precharges to it are refused. Its internal precharge starts at cycle t+BURST (default BURST 4), or later if T_RAS has not yet elapsed. Activate is allowed T_RP cycles after that start.
- R9: A write with auto-precharge at cycle t starts its internal precharge T_DPL cycles after the last beat, at cycle t+BURST-1+T_DPL (default T_DPL 1). The bank may be activated again T_RP cycles after that point.
- R10: Precharge-all is granted only when no bank is locked by auto-precharge and every open bank has met T_RAS. It closes all banks.
- R11: Refresh is granted only when every bank is closed and has finished both its T_RP and its T_RC spacing.
- R12: Command codes on `cmd_i`: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all, 6 refresh. Code 7 behaves as a no-op. A no-op is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Candidate command code |
| bank_i | input | BW (2) | Target bank |
| row_i | input | ROW_W (12) | Row for an activate |
| ap_i | input | 1 | Auto-precharge flag for read or write |
| grant_o | output | 1 | Candidate may issue this cycle |
| bank_open_o | output | NB (4) | Per-bank open flag |
| open_row_o | output | NB*ROW_W (48) | Per-bank latched row |

## Verification
A countdown that is loaded one value off, or a bank state that is wrong, shows up as a grant that flips one cycle early or late. This is visible in the exact cycle where a spacing limit expires. For that reason the stimulus places attempts on both sides of each limit: the cycle before, where the grant must be refused, and the first legal cycle, where it must be given. A bank stuck in the locked state, or closed too early, also changes `bank_open_o` on the cycle after its internal precharge begins. The same fault blocks the next activate or refresh. Row storage faults appear on `open_row_o` one cycle after the activate.

// File: rtl/bkt_pkg.sv
package bkt_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_PREA = 3'd5,
        CMD_REF  = 3'd6,
        CMD_RSV  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        BS_IDLE  = 2'd0,
        BS_OPEN  = 2'd1,
        BS_APW   = 2'd2
    } bank_st_e;

endpackage

// File: rtl/bkt_bank.sv
module bkt_bank
    import bkt_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int CW    = 4,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RC  = 9,
    parameter int T_RAS = 6,
    parameter int BURST = 4,
    parameter int T_DPL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             rw_go,
    input  logic             rw_wr,
    input  logic             rw_ap,
    input  logic             pre_go,
    input  logic             ref_go,
    input  logic [ROW_W-1:0] row_in,
    output logic             act_ok,
    output logic             rw_ok,
    output logic             pre_ok,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q
);

    localparam logic [CW-1:0] L_RCD  = CW'(T_RCD - 1);
    localparam logic [CW-1:0] L_RP   = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_RC   = CW'(T_RC - 1);
    localparam logic [CW-1:0] L_RAS  = CW'(T_RAS - 1);
    localparam logic [CW-1:0] L_APRD = CW'(BURST - 1);
    localparam logic [CW-1:0] L_APWR = CW'(BURST - 2 + T_DPL);
    localparam logic [CW-1:0] ZERO   = '0;

    bank_st_e        st_q, st_d;
    logic [CW-1:0]   rcd_q, ras_q, rc_q, rp_q, apw_q;
    logic            pre_evt;

    function automatic logic [CW-1:0] tick(input logic [CW-1:0] v);
        return (v == ZERO) ? ZERO : v - 1'b1;
    endfunction

    // next state
    always_comb begin
        st_d    = st_q;
        pre_evt = 1'b0;
        unique case (st_q)
            BS_IDLE: begin
                if (act_go) st_d = BS_OPEN;
            end
            BS_OPEN: begin
                if (pre_go) begin
                    st_d    = BS_IDLE;
                    pre_evt = 1'b1;
                end else if (rw_go && rw_ap) begin
                    st_d = BS_APW;
                end
            end
            BS_APW: begin
                if (apw_q == ZERO && ras_q == ZERO) begin
                    st_d    = BS_IDLE;
                    pre_evt = 1'b1;
                end
            end
            default: st_d = BS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BS_IDLE;
        else        st_q <= st_d;
    end

    // timing countdowns and row latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcd_q <= ZERO;
            ras_q <= ZERO;
            rc_q  <= ZERO;
            rp_q  <= ZERO;
            apw_q <= ZERO;
            row_q <= '0;
        end else begin
            rcd_q <= act_go ? L_RCD : tick(rcd_q);
            ras_q <= act_go ? L_RAS : tick(ras_q);
            rc_q  <= (act_go || ref_go) ? L_RC : tick(rc_q);
            rp_q  <= pre_evt ? L_RP : tick(rp_q);
            if (st_q == BS_OPEN && rw_go && rw_ap)
                apw_q <= rw_wr ? L_APWR : L_APRD;
            else
                apw_q <= tick(apw_q);
            if (act_go) row_q <= row_in;
        end
    end

    // outputs
    always_comb begin
        act_ok  = (st_q == BS_IDLE) && (rp_q == ZERO) && (rc_q == ZERO);
        rw_ok   = (st_q == BS_OPEN) && (rcd_q == ZERO);
        pre_ok  = (st_q == BS_IDLE) || ((st_q == BS_OPEN) && (ras_q == ZERO));
        is_open = (st_q != BS_IDLE);
    end

endmodule

// File: rtl/bkt_spacer.sv
module bkt_spacer #(
    parameter int CW    = 4,
    parameter int T_RRD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_any,
    output logic ok
);

    localparam logic [CW-1:0] L_RRD = CW'(T_RRD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (act_any)          cnt_q <= L_RRD;
        else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    assign ok = (cnt_q == '0);

endmodule

// File: rtl/bank_gate.sv
module bank_gate
    import bkt_pkg::*;
#(
    parameter int NB    = 4,
    parameter int ROW_W = 12,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RC  = 9,
    parameter int T_RRD = 2,
    parameter int T_RAS = 6,
    parameter int BURST = 4,
    parameter int T_DPL = 1,
    localparam int BW   = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cmd_i,
    input  logic [BW-1:0]       bank_i,
    input  logic [ROW_W-1:0]    row_i,
    input  logic                ap_i,
    output logic                grant_o,
    output logic [NB-1:0]       bank_open_o,
    output logic [NB*ROW_W-1:0] open_row_o
);

    localparam int M1   = (T_RC > T_RAS) ? T_RC : T_RAS;
    localparam int M2   = (BURST + T_DPL > M1) ? BURST + T_DPL : M1;
    localparam int M3   = (T_RP > M2) ? T_RP : M2;
    localparam int MAXT = (T_RRD > M3) ? T_RRD : M3;
    localparam int CW   = $clog2(MAXT + 1);

    cmd_e          cmd;
    logic [NB-1:0] act_ok, rw_ok, pre_ok, is_open;
    logic [NB-1:0] act_go, rw_go, pre_go;
    logic          rrd_ok, ref_go, act_any;
    logic [ROW_W-1:0] row_q [NB];

    assign cmd = cmd_e'(cmd_i);

    always_comb begin
        unique case (cmd)
            CMD_ACT:         grant_o = act_ok[bank_i] && rrd_ok;
            CMD_RD, CMD_WR:  grant_o = rw_ok[bank_i];
            CMD_PRE:         grant_o = pre_ok[bank_i];
            CMD_PREA:        grant_o = &pre_ok;
            CMD_REF:         grant_o = &act_ok;
            default:         grant_o = 1'b0;
        endcase
    end

    assign ref_go  = grant_o && (cmd == CMD_REF);
    assign act_any = grant_o && (cmd == CMD_ACT);

    bkt_spacer #(.CW(CW), .T_RRD(T_RRD)) u_rrd (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_any (act_any),
        .ok      (rrd_ok)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic sel;
        assign sel       = (bank_i == BW'(g));
        assign act_go[g] = act_any && sel;
        assign rw_go[g]  = grant_o && sel && (cmd == CMD_RD || cmd == CMD_WR);
        assign pre_go[g] = grant_o && ((cmd == CMD_PRE && sel) || cmd == CMD_PREA);

        bkt_bank #(
            .ROW_W (ROW_W), .CW (CW),
            .T_RCD (T_RCD), .T_RP (T_RP), .T_RC (T_RC),
            .T_RAS (T_RAS), .BURST (BURST), .T_DPL (T_DPL)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_go  (act_go[g]),
            .rw_go   (rw_go[g]),
            .rw_wr   (cmd == CMD_WR),
            .rw_ap   (ap_i),
            .pre_go  (pre_go[g]),
            .ref_go  (ref_go),
            .row_in  (row_i),
            .act_ok  (act_ok[g]),
            .rw_ok   (rw_ok[g]),
            .pre_ok  (pre_ok[g]),
            .is_open (is_open[g]),
            .row_q   (row_q[g])
        );

        assign open_row_o[g*ROW_W +: ROW_W] = row_q[g];
        assign bank_open_o[g]               = is_open[g];
    end

endmodule

// File: rtl/bkt_checker.sv
module bkt_checker #(
    parameter int NB    = 4,
    parameter int ROW_W = 12,
    parameter int T_RCD = 3,
    parameter int T_RRD = 2,
    localparam int BW   = (NB > 1) ? $clog2(NB) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          cmd_i,
    input logic [BW-1:0]       bank_i,
    input logic [ROW_W-1:0]    row_i,
    input logic                ap_i,
    input logic                grant_o,
    input logic [NB-1:0]       bank_open_o,
    input logic [NB*ROW_W-1:0] open_row_o
);

    localparam int unsigned LIM = 1023;

    int unsigned since_bank [NB];
    int unsigned since_any;
    logic act_g, rw_g;

    assign act_g = grant_o && (cmd_i == 3'd1);
    assign rw_g  = grant_o && (cmd_i == 3'd2 || cmd_i == 3'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) since_bank[i] <= LIM;
            since_any <= LIM;
        end else begin
            for (int i = 0; i < NB; i++) begin
                if (act_g && bank_i == BW'(i)) since_bank[i] <= 1;
                else if (since_bank[i] < LIM)  since_bank[i] <= since_bank[i] + 1;
            end
            if (act_g)                 since_any <= 1;
            else if (since_any < LIM)  since_any <= since_any + 1;
        end
    end

    assert_act_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_g |-> !bank_open_o[bank_i]);

    assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_g |=> bank_open_o[$past(bank_i)] &&
                  open_row_o[$past(bank_i)*ROW_W +: ROW_W] == $past(row_i));

    assert_rw_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rw_g |-> bank_open_o[bank_i]);

    assert_rw_rcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rw_g |-> since_bank[bank_i] >= T_RCD);

    assert_act_rrd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_g |-> since_any >= T_RRD);

    assert_prea_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && cmd_i == 3'd5) |=> bank_open_o == '0);

    assert_ref_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && cmd_i == 3'd6) |-> bank_open_o == '0);

    assert_nop_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd0 || cmd_i == 3'd7) |-> !grant_o);

endmodule

bind bank_gate bkt_checker #(
    .NB(NB), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RRD(T_RRD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i),
    .row_i(row_i), .ap_i(ap_i), .grant_o(grant_o),
    .bank_open_o(bank_open_o), .open_row_o(open_row_o)
);

// File: tb/sim_bank_gate.sv
module sim_bank_gate;

    localparam int NB    = 4;
    localparam int ROW_W = 12;

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                           PRE = 3'd4, PREA = 3'd5, REF = 3'd6, RSV = 3'd7;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [2:0]          cmd_i = NOP;
    logic [1:0]          bank_i = '0;
    logic [ROW_W-1:0]    row_i = '0;
    logic                ap_i = 1'b0;
    logic                grant_o;
    logic [NB-1:0]       bank_open_o;
    logic [NB*ROW_W-1:0] open_row_o;

    bank_gate u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i),
        .row_i(row_i), .ap_i(ap_i), .grant_o(grant_o),
        .bank_open_o(bank_open_o), .open_row_o(open_row_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic             g;
        logic [NB-1:0]    open;
        int               rb;
        logic [ROW_W-1:0] row;
        string            tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   drv_done = 0;
    bit   summ_done = 0;

    task automatic fail_line(input string tag, input string what,
                             input int act, input int exp);
        n_bad++;
        $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    endtask

    // driver: one call is one cycle
    task automatic step(input logic [2:0] c, input int b, input int r,
                        input logic ap, input logic eg, input logic [NB-1:0] eo,
                        input string tag, input int rb = -1, input int erow = 0);
        exp_t e;
        @(negedge clk);
        cmd_i  = c;
        bank_i = 2'(b);
        row_i  = ROW_W'(r);
        ap_i   = ap;
        e.g = eg; e.open = eo; e.rb = rb; e.row = ROW_W'(erow); e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n, input logic [NB-1:0] eo, input string tag);
        for (int i = 0; i < n; i++) step(NOP, 0, 0, 1'b0, 1'b0, eo, tag);
    endtask

    // monitor: pops and compares shortly after inputs settle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (grant_o !== e.g)
                    fail_line(e.tag, "grant", int'(grant_o), int'(e.g));
                else if (bank_open_o !== e.open)
                    fail_line(e.tag, "open", int'(bank_open_o), int'(e.open));
                else if (e.rb >= 0 && open_row_o[e.rb*ROW_W +: ROW_W] !== e.row)
                    fail_line(e.tag, "row", int'(open_row_o[e.rb*ROW_W +: ROW_W]), int'(e.row));
            end
        end
    end

    task automatic summary();
        if (!summ_done) begin
            summ_done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (bank_open_o !== '0 || open_row_o !== '0)
            fail_line("R1", "reset", int'(bank_open_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        step(REF,  0, 0,     0, 1, 4'b0000, "R11 refresh after reset");
        step(ACT,  0, 'h12,  0, 0, 4'b0000, "R5 refresh tRC");
        idle(6, 4'b0000, "R12 nop");
        step(ACT,  0, 'h12,  0, 0, 4'b0000, "R5 refresh tRC edge");
        step(ACT,  0, 'h12,  0, 1, 4'b0000, "R5 act after tRC");
        step(ACT,  1, 'h34,  0, 0, 4'b0001, "R4 tRRD refuse", 0, 'h12);
        step(ACT,  1, 'h34,  0, 1, 4'b0001, "R4 tRRD met");
        step(RD,   0, 0,     0, 1, 4'b0011, "R3 read at tRCD");
        step(RD,   1, 0,     0, 0, 4'b0011, "R3 read before tRCD");
        step(WR,   1, 0,     0, 1, 4'b0011, "R3 write at tRCD");
        step(PRE,  0, 0,     0, 1, 4'b0011, "R6 precharge at tRAS");
        step(RD,   2, 0,     0, 0, 4'b0010, "R3 read closed bank");
        step(ACT,  0, 'h55,  0, 0, 4'b0010, "R6 act during tRP");
        step(ACT,  0, 'h55,  0, 1, 4'b0010, "R6 act after tRP");
        step(PRE,  1, 0,     0, 1, 4'b0011, "R6 precharge bank1");
        step(PRE,  3, 0,     0, 1, 4'b0001, "R7 precharge idle bank");
        step(ACT,  3, 'h77,  0, 1, 4'b0001, "R7 act right after idle precharge", 0, 'h55);
        step(RD,   0, 0,     1, 1, 4'b1001, "R8 read auto-precharge");
        step(RD,   0, 0,     0, 0, 4'b1001, "R8 read refused while locked");
        step(PRE,  0, 0,     0, 0, 4'b1001, "R8 precharge refused while locked");
        step(PREA, 0, 0,     0, 0, 4'b1001, "R10 precharge-all refused");
        step(WR,   3, 0,     1, 1, 4'b1001, "R9 write auto-precharge");
        step(ACT,  0, 'h66,  0, 0, 4'b1000, "R8 bank closed, tRP pending");
        idle(1, 4'b1000, "R12 nop");
        step(ACT,  0, 'h66,  0, 1, 4'b1000, "R8 act after internal precharge");
        step(REF,  0, 0,     0, 0, 4'b1001, "R11 refresh with open banks");
        step(ACT,  3, 'h44,  0, 0, 4'b0001, "R9 tDAL refuse");
        step(ACT,  3, 'h44,  0, 0, 4'b0001, "R9 tDAL edge", 0, 'h66);
        step(ACT,  3, 'h44,  0, 1, 4'b0001, "R9 act after tDAL");
        step(ACT,  1, 'h21,  0, 0, 4'b1001, "R4 tRRD refuse again");
        step(ACT,  1, 'h21,  0, 1, 4'b1001, "R2 act bank1");
        step(PREA, 0, 0,     0, 0, 4'b1011, "R10 precharge-all before tRAS", 3, 'h44);
        idle(3, 4'b1011, "R12 nop");
        step(PREA, 0, 0,     0, 0, 4'b1011, "R10 precharge-all edge");
        step(PREA, 0, 0,     0, 1, 4'b1011, "R10 precharge-all granted");
        step(REF,  0, 0,     0, 0, 4'b0000, "R11 refresh during tRP");
        idle(1, 4'b0000, "R12 nop");
        step(REF,  0, 0,     0, 1, 4'b0000, "R11 refresh granted");
        step(RSV,  0, 0,     0, 0, 4'b0000, "R12 reserved code", 1, 'h21);
        step(NOP,  0, 0,     0, 0, 4'b0000, "R2 row held after close", 3, 'h44);

        @(negedge clk);
        cmd_i = NOP;
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        drv_done = 1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!drv_done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
        end
        summary();
    end

endmodule